// File: doc/BRIEF.md
# Tag-Based Reservation Station Bank

This block is a small pool of reservation stations that feeds one functional-unit class in an out-of-order core. An issue stage hands it one operation per cycle: an opcode, a destination register, two source registers with their register-file values, and an address field. For each source, the bank looks up its own register status table. A register with no pending producer supplies its value at once. A register that is still awaited supplies the tag of the station that will produce it.

A single result broadcast bus carries a tag and a value. Every waiting operand whose tag matches copies the value. Any register whose status names that tag becomes valid again. The station that owns the tag is freed. Once both operands of a station are present, the station competes for dispatch. The lowest-numbered ready station goes to the functional unit in any cycle where the unit is ready.

Tags run from 1 to the number of stations. Station i (counting from 0) has tag i+1, and tag 0 means "value present". Issuing an operation writes the new station's tag into its destination register's status entry. This renames the register, so later readers wait on the newest producer.

Top module: `rs_bank`

## Requirements
- R1: After reset all stations are free and every register status is zero. `iss_ready` is 1, `iss_tag` is 1 and `disp_valid` is 0, and an issued operation takes its sources from `iss_val1`/`iss_val2`.
- R2: `iss_ready` is 1 exactly when a station is free. An issue is accepted when `iss_valid` and `iss_ready` are both 1. It goes into the lowest-numbered free station, whose tag (index+1) is shown on `iss_tag` in that cycle.
- R3: With all stations busy, `iss_ready` is 0 and `iss_valid` has no effect: no station is filled and no register status changes.
- R4: An accepted issue sets its destination register's status to the new tag. Sources are looked up before that write, so a source equal to the destination waits on the previous producer. A later reader of that register waits on the new tag.
- R5: On a valid broadcast, every busy station operand whose tag equals `bc_tag` takes `bc_value` and its tag becomes 0. Every register whose status equals `bc_tag` returns to status 0, so later readers take the register-file value.
- R6: A station is ready only when busy, not yet dispatched, and both operand tags are 0. A consumer woken by a broadcast in cycle N is first offered for dispatch in cycle N+1.
- R7: `disp_valid` shows the lowest-numbered ready station on `disp_tag`. That station is dispatched at a clock edge only if `fu_ready` is 1. At most one station is dispatched per cycle, and a dispatched station is never offered again.
- R8: If an issued source's producer broadcasts in the same cycle as the issue, the operand is taken from the bus as a value and is not lost.
- R9: A station becomes free on the edge where its own tag is broadcast, and it can accept an issue in the next cycle.
- R10: A broadcast with `bc_valid` 0 changes nothing. A register renamed to a newer tag keeps that tag when an older producer's tag is broadcast.
- R11: With `disp_valid` 1, `disp_op`, `disp_a`, `disp_b` and `disp_addr` carry the opcode, first and second operand, and address of the station shown on `disp_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A station is free |
| iss_tag | output | TAG_W | Tag the next accepted issue receives |
| iss_op | input | OP_W | Opcode of the issued operation |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_val1 | input | DATA_W | Register-file value of the first source |
| iss_val2 | input | DATA_W | Register-file value of the second source |
| iss_addr | input | ADDR_W | Address field of the operation |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Functional unit accepts a dispatch |
| disp_valid | output | 1 | A ready station is offered |
| disp_tag | output | TAG_W | Tag of the offered station |
| disp_op | output | OP_W | Opcode of the offered station |
| disp_a | output | DATA_W | First operand of the offered station |
| disp_b | output | DATA_W | Second operand of the offered station |
| disp_addr | output | ADDR_W | Address field of the offered station |

## Verification
The bench builds the bank with its defaults: four stations, eight registers, 16-bit data, 4-bit opcodes and 12-bit addresses. With four stations the bank fills after four issues, so the stall at full occupancy, the refused issue and the reuse of a freed middle station can all be reached in a few cycles. With eight registers, a single register can be renamed twice while an older broadcast is still in flight. This shows both that the newer tag survives and that a source equal to its own destination waits on the previous producer.

// File: rtl/rs_pkg.sv
// Shared types for the reservation station bank.
// Assumes: tag value 0 is reserved for "operand present".
package rs_pkg;

    // Where an issued operand is taken from.
    typedef enum logic [1:0] {
        OPND_FILE = 2'd0,   // register has no pending producer
        OPND_BUS  = 2'd1,   // producer broadcasts in the issue cycle
        OPND_WAIT = 2'd2    // operand must be captured later by tag
    } opnd_src_e;

endpackage

// File: rtl/rs_pick.sv
// Lowest-index picker: grants the lowest set request bit and reports its index.
// Assumes: N >= 1; used for free-station allocation and for dispatch selection.
module rs_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Isolate the lowest set bit and encode it.
    always_comb begin
        gnt = req & (~req + 1'b1);
        any = |req;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
        end
    end

endmodule

// File: rtl/rs_regstat.sv
// Register status table: one producer tag per architectural register.
// A write from issue takes priority over a clear from the broadcast bus.
// Assumes: tag 0 means the register-file value is current.
module rs_regstat #(
    parameter int NUM_REGS = 8,
    parameter int TAG_W    = 3,
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] rd1_idx,
    input  logic [REG_W-1:0] rd2_idx,
    output logic [TAG_W-1:0] rd1_tag,
    output logic [TAG_W-1:0] rd2_tag,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag
);

    logic [TAG_W-1:0] stat [NUM_REGS];

    // Read ports: status as it stands before this cycle's update.
    assign rd1_tag = stat[rd1_idx];
    assign rd2_tag = stat[rd2_idx];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        // Rename on issue, otherwise clear when the named producer broadcasts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat[gi] <= '0;
            end else if (wr_en && wr_idx == REG_W'(gi)) begin
                stat[gi] <= wr_tag;
            end else if (bc_valid && stat[gi] != '0 && stat[gi] == bc_tag) begin
                stat[gi] <= '0;
            end
        end

        // R4: an issue renames its destination to the new tag.
        p_rename_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == REG_W'(gi)) |=> (stat[gi] == $past(wr_tag)));

        // R5: a broadcast of the pending tag makes the register valid again.
        p_stat_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && stat[gi] != '0 && stat[gi] == bc_tag &&
             !(wr_en && wr_idx == REG_W'(gi))) |=> (stat[gi] == '0));
    end

endmodule

// File: rtl/rs_entry.sv
// One reservation station: opcode, two operand slots (tag or value), address,
// busy and dispatched flags. Snoops the broadcast bus for its pending operands
// and frees itself when its own tag is broadcast.
// Assumes: alloc is only raised while the station is free.
module rs_entry #(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int ADDR_W = 12,
    parameter logic [TAG_W-1:0] MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   a_op,
    input  logic [TAG_W-1:0]  a_q1,
    input  logic [DATA_W-1:0] a_v1,
    input  logic [TAG_W-1:0]  a_q2,
    input  logic [DATA_W-1:0] a_v2,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              launch,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] v1,
    output logic [DATA_W-1:0] v2,
    output logic [ADDR_W-1:0] addr
);

    logic             sent;
    logic [TAG_W-1:0] q1, q2;

    // Fill on allocation; otherwise capture operands, mark dispatch, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sent <= 1'b0;
            q1   <= '0;
            q2   <= '0;
            v1   <= '0;
            v2   <= '0;
            op   <= '0;
            addr <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            sent <= 1'b0;
            op   <= a_op;
            addr <= a_addr;
            q1   <= a_q1;
            v1   <= a_v1;
            q2   <= a_q2;
            v2   <= a_v2;
        end else begin
            if (launch) sent <= 1'b1;
            if (busy && bc_valid && bc_tag == MY_TAG) busy <= 1'b0;
            if (bc_valid && q1 != '0 && bc_tag == q1) begin
                q1 <= '0;
                v1 <= bc_value;
            end
            if (bc_valid && q2 != '0 && bc_tag == q2) begin
                q2 <= '0;
                v2 <= bc_value;
            end
        end
    end

    // Ready: both operands present and not yet sent.
    assign ready = busy && !sent && q1 == '0 && q2 == '0;

    // R2: allocation only targets a free station.
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !busy);

    // R6: dispatch only with both operand tags zero.
    p_launch_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (busy && !sent && q1 == '0 && q2 == '0));

    // R7: a dispatched station is not offered again.
    p_no_relaunch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !ready);

    // R5: a matching broadcast fills the first operand and clears its tag.
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !alloc && bc_valid && q1 != '0 && bc_tag == q1)
        |=> (q1 == '0 && v1 == $past(bc_value)));

    // R9: the station frees when its own tag is broadcast.
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !alloc && bc_valid && bc_tag == MY_TAG) |=> !busy);

endmodule

// File: rtl/rs_bank.sv
// Reservation station bank for one functional-unit class. Resolves issued
// sources against the register status table (and the same-cycle broadcast),
// allocates the lowest free station, renames the destination, and offers the
// lowest ready station to the functional unit.
// Assumes: at most one issue and one broadcast per cycle; tags are 1..NUM_RS.
module rs_bank
    import rs_pkg::*;
#(
    parameter int NUM_RS   = 4,
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int OP_W     = 4,
    parameter int ADDR_W   = 12,
    localparam int TAG_W   = $clog2(NUM_RS + 1),
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int IDX_W   = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    input  logic [DATA_W-1:0] iss_val1,
    input  logic [DATA_W-1:0] iss_val2,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              fu_ready,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [ADDR_W-1:0] disp_addr
);

    logic [NUM_RS-1:0] busy_vec, ready_vec, free_gnt, rdy_gnt, alloc_vec, launch_vec;
    logic [IDX_W-1:0]  free_idx, disp_idx;
    logic              iss_fire;
    logic [TAG_W-1:0]  st1, st2, q1_new, q2_new;
    logic [DATA_W-1:0] v1_new, v2_new;

    logic [OP_W-1:0]   e_op   [NUM_RS];
    logic [DATA_W-1:0] e_v1   [NUM_RS];
    logic [DATA_W-1:0] e_v2   [NUM_RS];
    logic [ADDR_W-1:0] e_addr [NUM_RS];

    // Choose where an issued operand comes from: file, bus, or a later capture.
    function automatic opnd_src_e classify(input logic [TAG_W-1:0] st,
                                           input logic             bv,
                                           input logic [TAG_W-1:0] bt);
        if (st == '0)            return OPND_FILE;
        else if (bv && bt == st) return OPND_BUS;
        else                     return OPND_WAIT;
    endfunction

    // Free-station allocator.
    rs_pick #(.N(NUM_RS)) i_free_pick (
        .req (~busy_vec),
        .gnt (free_gnt),
        .any (iss_ready),
        .idx (free_idx)
    );

    assign iss_tag   = TAG_W'(free_idx) + 1'b1;
    assign iss_fire  = iss_valid && iss_ready;
    assign alloc_vec = free_gnt & {NUM_RS{iss_fire}};

    // Register status table.
    rs_regstat #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) i_regstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd1_idx  (iss_src1),
        .rd2_idx  (iss_src2),
        .rd1_tag  (st1),
        .rd2_tag  (st2),
        .wr_en    (iss_fire),
        .wr_idx   (iss_dst),
        .wr_tag   (iss_tag),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag)
    );

    // Resolve both issued operands into a tag/value pair.
    always_comb begin
        unique case (classify(st1, bc_valid, bc_tag))
            OPND_FILE: begin q1_new = '0;  v1_new = iss_val1; end
            OPND_BUS:  begin q1_new = '0;  v1_new = bc_value; end
            default:   begin q1_new = st1; v1_new = '0;       end
        endcase
        unique case (classify(st2, bc_valid, bc_tag))
            OPND_FILE: begin q2_new = '0;  v2_new = iss_val2; end
            OPND_BUS:  begin q2_new = '0;  v2_new = bc_value; end
            default:   begin q2_new = st2; v2_new = '0;       end
        endcase
    end

    // Station array.
    for (genvar gi = 0; gi < NUM_RS; gi++) begin : g_rs
        rs_entry #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .ADDR_W (ADDR_W),
            .MY_TAG (TAG_W'(gi + 1))
        ) i_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_vec[gi]),
            .a_op     (iss_op),
            .a_q1     (q1_new),
            .a_v1     (v1_new),
            .a_q2     (q2_new),
            .a_v2     (v2_new),
            .a_addr   (iss_addr),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_value (bc_value),
            .launch   (launch_vec[gi]),
            .busy     (busy_vec[gi]),
            .ready    (ready_vec[gi]),
            .op       (e_op[gi]),
            .v1       (e_v1[gi]),
            .v2       (e_v2[gi]),
            .addr     (e_addr[gi])
        );
    end

    // Dispatch selector: lowest ready station, consumed when the unit is ready.
    rs_pick #(.N(NUM_RS)) i_rdy_pick (
        .req (ready_vec),
        .gnt (rdy_gnt),
        .any (disp_valid),
        .idx (disp_idx)
    );

    assign launch_vec = rdy_gnt & {NUM_RS{fu_ready}};
    assign disp_tag   = TAG_W'(disp_idx) + 1'b1;
    assign disp_op    = e_op[disp_idx];
    assign disp_a     = e_v1[disp_idx];
    assign disp_b     = e_v2[disp_idx];
    assign disp_addr  = e_addr[disp_idx];

endmodule

// File: tb/test_rs_bank.sv
`timescale 1ns/1ps
module test_rs_bank;

    localparam int NUM_RS = 4, NUM_REGS = 8, DATA_W = 16, OP_W = 4, ADDR_W = 12;
    localparam int TAG_W = 3, REG_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0, iss_ready;
    logic [TAG_W-1:0]  iss_tag;
    logic [OP_W-1:0]   iss_op = '0;
    logic [REG_W-1:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [DATA_W-1:0] iss_val1 = '0, iss_val2 = '0;
    logic [ADDR_W-1:0] iss_addr = '0;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_value = '0;
    logic              fu_ready = 1'b0, disp_valid;
    logic [TAG_W-1:0]  disp_tag;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_a, disp_b;
    logic [ADDR_W-1:0] disp_addr;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rs_bank #(.NUM_RS(NUM_RS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
              .OP_W(OP_W), .ADDR_W(ADDR_W)) i_rs_bank (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_val1(iss_val1), .iss_val2(iss_val2), .iss_addr(iss_addr),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b), .disp_addr(disp_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_issue(input int op, input int dst, input int s1, input int s2,
                             input int v1, input int v2, input int addr);
        iss_valid = 1'b1;
        iss_op    = OP_W'(op);
        iss_dst   = REG_W'(dst);
        iss_src1  = REG_W'(s1);
        iss_src2  = REG_W'(s2);
        iss_val1  = DATA_W'(v1);
        iss_val2  = DATA_W'(v2);
        iss_addr  = ADDR_W'(addr);
    endtask

    task automatic put_bc(input bit valid, input int tag, input int value);
        bc_valid = valid;
        bc_tag   = TAG_W'(tag);
        bc_value = DATA_W'(value);
    endtask

    // One clock: inputs set at a falling edge are taken at the rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        bc_valid  = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        iss_valid = 1'b0;
        bc_valid = 1'b0;
        fu_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "iss_ready", 32'(iss_ready), 1);
        chk("R1", "iss_tag", 32'(iss_tag), 1);
        chk("R1", "disp_valid", 32'(disp_valid), 0);
        put_issue(3, 1, 3, 4, 'habc, 'h5, 'h7);
        tick();
        chk("R1", "operand from file", 32'(disp_a), 'habc);
        chk("R1", "disp_valid after issue", 32'(disp_valid), 1);
    endtask

    task automatic t_fill_order();
        do_reset();
        for (int k = 0; k < NUM_RS; k++) begin
            chk("R2", "iss_tag while filling", 32'(iss_tag), 32'(k + 1));
            put_issue(k + 1, k + 1, 0, 0, 'h100 + k, 'h200 + k, 'h10 + k);
            tick();
        end
        chk("R3", "iss_ready when full", 32'(iss_ready), 0);
        put_issue(9, 7, 0, 0, 1, 1, 1);   // refused: bank full
        tick();
        chk("R3", "iss_ready still low", 32'(iss_ready), 0);
        chk("R7", "offered before fu_ready", 32'(disp_tag), 1);
        tick();
        chk("R7", "held without fu_ready", 32'(disp_tag), 1);
        fu_ready = 1'b1;
        for (int k = 0; k < NUM_RS; k++) begin
            chk("R7", "dispatch order", 32'(disp_tag), 32'(k + 1));
            chk("R11", "disp_op", 32'(disp_op), 32'(k + 1));
            chk("R11", "disp_a", 32'(disp_a), 32'('h100 + k));
            chk("R11", "disp_b", 32'(disp_b), 32'('h200 + k));
            chk("R11", "disp_addr", 32'(disp_addr), 32'('h10 + k));
            tick();
        end
        fu_ready = 1'b0;
        chk("R7", "no re-dispatch", 32'(disp_valid), 0);
        put_bc(1'b1, 2, 0);
        tick();
        chk("R9", "iss_ready after release", 32'(iss_ready), 1);
        chk("R9", "freed middle station", 32'(iss_tag), 2);
        put_issue(5, 6, 7, 0, 'h77, 1, 0);
        tick();
        chk("R3", "refused issue left r7 valid", 32'(disp_a), 'h77);
        chk("R3", "reader dispatchable", 32'(disp_tag), 2);
    endtask

    task automatic t_wakeup();
        do_reset();
        put_issue(1, 5, 0, 0, 1, 2, 0);          // producer, tag 1
        tick();
        put_issue(2, 6, 5, 0, 'hdead, 7, 0);     // consumer of r5, tag 2
        tick();
        chk("R6", "producer offered", 32'(disp_tag), 1);
        fu_ready = 1'b1;
        tick();
        chk("R6", "consumer waits on tag", 32'(disp_valid), 0);
        put_bc(1'b1, 1, 'h55);
        chk("R6", "not ready in broadcast cycle", 32'(disp_valid), 0);
        tick();
        chk("R6", "ready cycle after broadcast", 32'(disp_valid), 1);
        chk("R5", "woken station", 32'(disp_tag), 2);
        chk("R5", "captured value", 32'(disp_a), 'h55);
        chk("R5", "other operand", 32'(disp_b), 7);
        tick();
        put_issue(3, 7, 5, 0, 'h99, 3, 0);
        tick();
        chk("R5", "status cleared, file value", 32'(disp_a), 'h99);
        chk("R5", "reader placed in tag 1", 32'(disp_tag), 1);
        fu_ready = 1'b0;
    endtask

    task automatic t_bypass();
        do_reset();
        put_issue(1, 3, 0, 0, 0, 0, 0);          // producer of r3, tag 1
        tick();
        put_issue(6, 5, 3, 0, 'hbad, 9, 0);      // consumer, tag 2
        put_bc(1'b1, 1, 'h1234);                 // producer result same cycle
        tick();
        chk("R8", "consumer ready", 32'(disp_valid), 1);
        chk("R8", "consumer tag", 32'(disp_tag), 2);
        chk("R8", "bypassed value", 32'(disp_a), 'h1234);
        chk("R9", "producer freed", 32'(iss_tag), 1);
        put_issue(4, 6, 3, 0, 'h42, 0, 0);
        tick();
        fu_ready = 1'b1;
        chk("R5", "r3 status cleared", 32'(disp_a), 'h42);
        chk("R7", "lowest ready first", 32'(disp_tag), 1);
        tick();
        chk("R7", "next ready", 32'(disp_tag), 2);
        tick();
        fu_ready = 1'b0;
    endtask

    task automatic t_rename();
        do_reset();
        put_issue(1, 2, 0, 0, 1, 1, 0);          // A: r2, tag 1
        tick();
        put_issue(2, 2, 2, 0, 'hdead, 5, 0);     // B: r2 <- f(r2), tag 2
        tick();
        put_bc(1'b1, 1, 'h11);                   // A result
        tick();
        chk("R9", "A freed", 32'(iss_tag), 1);
        put_issue(3, 4, 2, 0, 'hbeef, 6, 0);     // C reads r2: must wait on tag 2
        tick();
        put_bc(1'b0, 2, 'h33);                   // invalid broadcast
        tick();
        fu_ready = 1'b1;
        chk("R4", "B woken by previous producer", 32'(disp_tag), 2);
        chk("R4", "B operand", 32'(disp_a), 'h11);
        tick();
        chk("R10", "C not woken by invalid/old tag", 32'(disp_valid), 0);
        put_bc(1'b1, 2, 'h22);
        tick();
        chk("R10", "C woken by newest tag", 32'(disp_tag), 1);
        chk("R4", "C operand", 32'(disp_a), 'h22);
        tick();
        fu_ready = 1'b0;
    endtask

    initial begin
        t_reset();
        t_fill_order();
        t_wakeup();
        t_bypass();
        t_rename();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule